// File: doc/BRIEF.md
# Event Record Framer

This block turns each trigger accept into one complete event record on an 18-bit valid/ready word stream. When the accept arrives, the block takes a snapshot of the trigger and status inputs: the event counter, the bunch-crossing number, the data-available and active flags, the crate and board identity, the overlap flags, the FIFO flags and a 4-bit free-running counter. It places the snapshot in a small queue. A sequencer takes snapshots from the queue one at a time. For each one it emits eight header words, then the payload of every flagged source, then eight trailer words.

There are seven payload sources, each a 12-bit word stream with a valid, a last marker and a ready. They are scanned in a fixed order: anode (index 0), trigger board (index 1), then cathode channels 0 to 4 (indices 2 to 6). A source that is flagged as available but goes silent, or that never sends its last marker, is stopped by a programmable cycle limit. The stop is recorded in the trailer.

Top module: `evt_rec_packer`

## Requirements
- R1: Header words, in order, carry in bits 11:0: {tbrd_dav, cfeb_active, cfeb_dav}; evt_count[11:0]; evt_count[23:12]; bx_num; a copy of header 1; {crate_id, board_id}; {ovlp_flags, fifo_half}; {8'b0, free counter}. All fields are sampled on the accept cycle.
- R2: Payload is taken only from flagged sources. Anode is flagged by anode_dav, the trigger board by a nonzero tbrd_dav, and cathode k by cfeb_dav[k]. The scan order is source index 0 to 6. Words from an unflagged source are never accepted, even while its valid is high.
- R3: Trailer words, in order, carry: a copy of header 1; a copy of header 7; {length[7:0], bx_num[3:0]}; a copy of header 6; {fifo_empty, fifo_full}; then the timeout word {no_data[5:0], no_end[5:0]}, three times.
- R4: Header and trailer words have bit 12 set. Payload words have bit 12 clear and carry the source word in bits 11:0. Bits 17:13 are always zero.
- R5: Every accept yields exactly one record, in accept order. An accept with no flagged source yields 16 words. Up to Q_DEPTH accepts may wait while a record streams. An accept while the queue is full is not allowed.
- R6: A flagged source counts the cycles in which it is granted. If it has sent no word by the time that count reaches tmo_limit (0 acts as 1), it is skipped and its no-data bit is set. Cathode k maps to bit k. Anode and trigger board share bit 5.
- R7: If a flagged source that has already sent words reaches the same limit without a last marker, it is cut off and its no-end bit is set, using the same bit map. The words it already sent stay in the record.
- R8: The length field counts the payload words of the record and saturates at 255.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: The free counter is 0 in the first cycle after reset and increases by one each clock. Header 8 carries its value in the accept cycle.
- R11: At most one src_ready bit is high. None is high while the output word is stalled or after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_accept | input | 1 | Trigger accept pulse; snapshots the status inputs |
| evt_count | input | 24 | Trigger-accept event counter |
| bx_num | input | 12 | Bunch-crossing number |
| anode_dav | input | 1 | Anode data available |
| tbrd_dav | input | 2 | Trigger-board data-available flags |
| cfeb_active | input | 5 | Cathode channel active flags |
| cfeb_dav | input | 5 | Cathode channel data-available flags |
| crate_id | input | 8 | Crate identity |
| board_id | input | 4 | Board identity |
| ovlp_flags | input | 5 | Multi-overlap flags |
| fifo_half | input | 7 | FIFO half-full flags |
| fifo_empty | input | 6 | FIFO empty flags |
| fifo_full | input | 6 | FIFO full flags |
| tmo_limit | input | TMO_W | Per-source cycle limit |
| src_valid | input | 7 | Per-source word valid |
| src_data | input | 84 | Per-source 12-bit words, source i at bits 12i+11:12i |
| src_last | input | 7 | Per-source end marker, qualified by valid |
| src_ready | output | 7 | Per-source word accept |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accept |
| out_data | output | 18 | Output word |

## Verification
Two things can happen in the same cycle: a new accept being pushed into the snapshot queue, and the sequencer popping the queue to start a record. The bench provokes this with accepts on consecutive cycles while the output is stalled at random, so one accept lands on the pop cycle. It judges the result by the headers that come out: every record must appear in accept order, with its own event counter, bunch-crossing number and free-counter value. A second collision is a source word arriving while the output slot is stalled. There the bench checks that every held word stays stable and that no payload word is lost or duplicated.

// File: rtl/evp_pkg.sv
package evp_pkg;
  localparam int N_SRC  = 7;
  localparam int FLD_W  = 12;
  localparam int WORD_W = 18;
  localparam int FLG_W  = 6;
  localparam int LEN_W  = 8;
  localparam int SEQ_W  = 3;

  typedef struct packed {
    logic              anode;
    logic [FLD_W-1:0]  h1;
    logic [23:0]       evt;
    logic [FLD_W-1:0]  bx;
    logic [FLD_W-1:0]  h6;
    logic [FLD_W-1:0]  h7;
    logic [3:0]        fr;
    logic [FLD_W-1:0]  t5;
  } snap_t;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_SRC, S_TRL} seq_st_e;

  function automatic logic [FLG_W-1:0] flag_of(input logic [SEQ_W-1:0] s);
    logic [FLG_W-1:0] f;
    f = '0;
    if (s < 3'd2) f[FLG_W-1] = 1'b1;
    else          f[s - 3'd2] = 1'b1;
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] frame_w(input logic [FLD_W-1:0] f);
    return {5'b0, 1'b1, f};
  endfunction
endpackage

// File: rtl/evp_snap_fifo.sv
module evp_snap_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/evp_src_sel.sv
module evp_src_sel #(
  parameter int N  = 7,
  parameter int DW = 12,
  parameter int SW = 3
) (
  input  logic [SW-1:0]   sel,
  input  logic            grant,
  input  logic [N-1:0]    src_valid,
  input  logic [N*DW-1:0] src_data,
  input  logic [N-1:0]    src_last,
  output logic            sel_valid,
  output logic [DW-1:0]   sel_data,
  output logic            sel_last,
  output logic [N-1:0]    src_ready
);
  always_comb begin
    sel_valid = 1'b0;
    sel_data  = '0;
    sel_last  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) begin
        sel_valid = src_valid[i];
        sel_data  = src_data[i*DW +: DW];
        sel_last  = src_last[i];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign src_ready[g] = grant && (sel == SW'(g));
  end
endmodule

// File: rtl/evp_event_seq.sv
module evp_event_seq
  import evp_pkg::*;
#(
  parameter int TMO_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  snap_t               snap,
  input  logic                snap_avail,
  output logic                snap_pop,
  input  logic [TMO_W-1:0]    tmo_limit,
  output logic [SEQ_W-1:0]    sel_idx,
  output logic                grant,
  input  logic                sel_valid,
  input  logic [FLD_W-1:0]    sel_data,
  input  logic                sel_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data
);
  localparam logic [SEQ_W-1:0] LAST_SEQ = SEQ_W'(7);
  localparam logic [SEQ_W-1:0] LAST_SRC = SEQ_W'(N_SRC - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;

  seq_st_e          st;
  logic [SEQ_W-1:0] idx;
  snap_t            cur;
  logic [LEN_W-1:0] len;
  logic [FLG_W-1:0] nd, ne;
  logic             got;
  logic [TMO_W-1:0] tcnt, lim_m1;
  logic [7:0]       avail;
  logic             slot_free, fire, emit_pl, tmo_hit, src_next, nd_set, ne_set;
  logic [FLD_W-1:0] hdr_f, trl_f;

  always_comb begin
    avail     = {1'b0, cur.h1[4:0], |cur.h1[11:10], cur.anode};
    slot_free = !out_valid || out_ready;
    lim_m1    = (tmo_limit == '0) ? '0 : tmo_limit - 1'b1;
    fire      = (tcnt >= lim_m1);
    grant     = (st == S_SRC) && avail[idx] && slot_free;
    snap_pop  = (st == S_IDLE) && snap_avail;
    emit_pl   = grant && sel_valid;
    tmo_hit   = grant && !(sel_valid && sel_last) && fire;
    nd_set    = tmo_hit && !got && !sel_valid;
    ne_set    = tmo_hit && (got || sel_valid);
    src_next  = (st == S_SRC) && (!avail[idx] || (emit_pl && sel_last) || tmo_hit);
    sel_idx   = idx;
    case (idx)
      3'd0:    hdr_f = cur.h1;
      3'd1:    hdr_f = cur.evt[11:0];
      3'd2:    hdr_f = cur.evt[23:12];
      3'd3:    hdr_f = cur.bx;
      3'd4:    hdr_f = cur.h1;
      3'd5:    hdr_f = cur.h6;
      3'd6:    hdr_f = cur.h7;
      default: hdr_f = {8'b0, cur.fr};
    endcase
    case (idx)
      3'd0:    trl_f = cur.h1;
      3'd1:    trl_f = cur.h7;
      3'd2:    trl_f = {len, cur.bx[3:0]};
      3'd3:    trl_f = cur.h6;
      3'd4:    trl_f = cur.t5;
      default: trl_f = {nd, ne};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      cur       <= '0;
      len       <= '0;
      nd        <= '0;
      ne        <= '0;
      got       <= 1'b0;
      tcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (snap_avail) begin
            cur <= snap;
            st  <= S_HDR;
            idx <= '0;
            len <= '0;
            nd  <= '0;
            ne  <= '0;
          end
        end
        S_HDR: begin
          if (slot_free) begin
            out_valid <= 1'b1;
            out_data  <= frame_w(hdr_f);
            if (idx == LAST_SEQ) begin
              st   <= S_SRC;
              idx  <= '0;
              tcnt <= '0;
              got  <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_SRC: begin
          if (emit_pl) begin
            out_valid <= 1'b1;
            out_data  <= {5'b0, 1'b0, sel_data};
            if (len != LEN_MAX) len <= len + 1'b1;
            got <= 1'b1;
          end
          if (grant)  tcnt <= tcnt + 1'b1;
          if (nd_set) nd <= nd | flag_of(idx);
          if (ne_set) ne <= ne | flag_of(idx);
          if (src_next) begin
            tcnt <= '0;
            got  <= 1'b0;
            if (idx == LAST_SRC) begin
              st  <= S_TRL;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          if (slot_free) begin
            out_valid <= 1'b1;
            out_data  <= frame_w(trl_f);
            if (idx == LAST_SEQ) st <= S_IDLE;
            else                 idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evt_rec_packer.sv
module evt_rec_packer
  import evp_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  parameter int TMO_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig_accept,
  input  logic [23:0]             evt_count,
  input  logic [11:0]             bx_num,
  input  logic                    anode_dav,
  input  logic [1:0]              tbrd_dav,
  input  logic [4:0]              cfeb_active,
  input  logic [4:0]              cfeb_dav,
  input  logic [7:0]              crate_id,
  input  logic [3:0]              board_id,
  input  logic [4:0]              ovlp_flags,
  input  logic [6:0]              fifo_half,
  input  logic [5:0]              fifo_empty,
  input  logic [5:0]              fifo_full,
  input  logic [TMO_W-1:0]        tmo_limit,
  input  logic [6:0]              src_valid,
  input  logic [7*12-1:0]         src_data,
  input  logic [6:0]              src_last,
  output logic [6:0]              src_ready,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [17:0]             out_data
);
  localparam int SNAP_W = $bits(snap_t);

  logic [3:0]       free_cnt;
  snap_t            snap_in, snap_out;
  logic [SNAP_W-1:0] q_dout;
  logic             q_empty, q_full, q_pop;
  logic [SEQ_W-1:0] sel_idx;
  logic             grant, sel_valid, sel_last;
  logic [FLD_W-1:0] sel_data;

  always_ff @(posedge clk) begin
    if (rst) free_cnt <= '0;
    else     free_cnt <= free_cnt + 1'b1;
  end

  always_comb begin
    snap_in.anode = anode_dav;
    snap_in.h1    = {tbrd_dav, cfeb_active, cfeb_dav};
    snap_in.evt   = evt_count;
    snap_in.bx    = bx_num;
    snap_in.h6    = {crate_id, board_id};
    snap_in.h7    = {ovlp_flags, fifo_half};
    snap_in.fr    = free_cnt;
    snap_in.t5    = {fifo_empty, fifo_full};
  end

  evp_snap_fifo #(.DEPTH(Q_DEPTH), .W(SNAP_W)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (trig_accept),
    .din   (snap_in),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  assign snap_out = snap_t'(q_dout);

  evp_src_sel #(.N(N_SRC), .DW(FLD_W), .SW(SEQ_W)) u_sel (
    .sel       (sel_idx),
    .grant     (grant),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_last  (src_last),
    .sel_valid (sel_valid),
    .sel_data  (sel_data),
    .sel_last  (sel_last),
    .src_ready (src_ready)
  );

  evp_event_seq #(.TMO_W(TMO_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .snap       (snap_out),
    .snap_avail (!q_empty),
    .snap_pop   (q_pop),
    .tmo_limit  (tmo_limit),
    .sel_idx    (sel_idx),
    .grant      (grant),
    .sel_valid  (sel_valid),
    .sel_data   (sel_data),
    .sel_last   (sel_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );
endmodule

// File: rtl/evp_packer_chk.sv
module evp_packer_chk (
  input logic        clk,
  input logic        rst,
  input logic        trig_accept,
  input logic        q_full,
  input logic [6:0]  src_valid,
  input logic [6:0]  src_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [17:0] out_data
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[17:13] == 5'b0));

  a_r4_payload_unmarked: assert property (@(posedge clk) disable iff (rst)
    (|(src_valid & src_ready)) |=> (out_valid && !out_data[12]));

  a_r11_one_ready: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ready));

  a_r11_no_ready_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> (src_ready == 7'b0));

  a_r5_queue_room: assert property (@(posedge clk) disable iff (rst)
    trig_accept |-> !q_full);
endmodule

bind evt_rec_packer evp_packer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig_accept (trig_accept),
  .q_full      (q_full),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/evt_rec_packer_tb_top.sv
module evt_rec_packer_tb_top;
  localparam int TMO_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              trig_accept = 1'b0;
  logic [23:0]       evt_count = '0;
  logic [11:0]       bx_num = '0;
  logic              anode_dav = 1'b0;
  logic [1:0]        tbrd_dav = '0;
  logic [4:0]        cfeb_active = '0, cfeb_dav = '0, ovlp_flags = '0;
  logic [7:0]        crate_id = '0;
  logic [3:0]        board_id = '0;
  logic [6:0]        fifo_half = '0;
  logic [5:0]        fifo_empty = '0, fifo_full = '0;
  logic [TMO_W-1:0]  tmo_limit = 12'd20;
  logic [6:0]        src_valid, src_last, src_ready;
  logic [83:0]       src_data;
  logic              out_valid, out_ready = 1'b0;
  logic [17:0]       out_data;

  evt_rec_packer #(.Q_DEPTH(4), .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst(rst), .trig_accept(trig_accept), .evt_count(evt_count),
    .bx_num(bx_num), .anode_dav(anode_dav), .tbrd_dav(tbrd_dav),
    .cfeb_active(cfeb_active), .cfeb_dav(cfeb_dav), .crate_id(crate_id),
    .board_id(board_id), .ovlp_flags(ovlp_flags), .fifo_half(fifo_half),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .tmo_limit(tmo_limit),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .src_ready(src_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int md [7];
  int nw [7];
  int ptr [7];
  logic clr = 1'b0;
  logic tag = 1'b0;
  int rdy_pct = 100;

  logic [17:0] exp_w [0:4095];
  int          exp_r [0:4095];
  int          exp_n = 0;
  logic [17:0] rx_w [0:4095];
  int          rx_n = 0;
  int          cmp_i = 0;
  logic        hold_pend = 1'b0;
  logic [17:0] held;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    for (int i = 0; i < 7; i++) begin
      if (clr) ptr[i] <= 0;
      else if (src_valid[i] && src_ready[i]) ptr[i] <= ptr[i] + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      src_valid[i] = (md[i] == 1 || md[i] == 3 || md[i] == 4) && (ptr[i] < nw[i]);
      src_last[i]  = (md[i] == 1) && (ptr[i] == nw[i] - 1);
      src_data[i*12 +: 12] = {3'(i), tag, ptr[i][7:0]};
    end
  end

  function automatic string rq(input int k);
    case (k)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq(k), what, act, expv);
    end
  endtask

  // collector: output handshake sampled away from the active edge (R9 hold)
  always @(negedge clk) begin
    logic r;
    if (hold_pend)
      check(out_valid && out_data == held, 9, "held word changed", {13'b0, out_valid, out_data}, {14'b1, held});
    r = ($urandom % 100) < rdy_pct;
    out_ready <= r;
    if (!rst && out_valid && r) begin
      rx_w[rx_n] = out_data;
      rx_n = rx_n + 1;
    end
    hold_pend = !rst && out_valid && !r;
    held = out_data;
  end

  task automatic push_exp(input logic [11:0] f, input bit mark, input int k);
    exp_w[exp_n] = {5'b0, mark, f};
    exp_r[exp_n] = k;
    exp_n++;
  endtask

  function automatic bit avail_of(input int s);
    if (s == 0) return anode_dav;
    if (s == 1) return |tbrd_dav;
    return cfeb_dav[s-2];
  endfunction

  // expected record from the requirements, built at the accept cycle
  task automatic build_exp();
    logic [11:0] h1, h6, h7, t5;
    logic [5:0] nd, ne;
    int len;
    h1 = {tbrd_dav, cfeb_active, cfeb_dav};
    h6 = {crate_id, board_id};
    h7 = {ovlp_flags, fifo_half};
    t5 = {fifo_empty, fifo_full};
    nd = '0; ne = '0; len = 0;
    push_exp(h1, 1, 1); push_exp(evt_count[11:0], 1, 1);
    push_exp(evt_count[23:12], 1, 1); push_exp(bx_num, 1, 1);
    push_exp(h1, 1, 1); push_exp(h6, 1, 1); push_exp(h7, 1, 1);
    push_exp({8'b0, 4'(cyc)}, 1, 10);
    for (int s = 0; s < 7; s++) begin
      if (avail_of(s)) begin
        if (md[s] == 1 || md[s] == 3) begin
          for (int p = 0; p < nw[s]; p++) begin
            push_exp({3'(s), tag, 8'(p)}, 0, (md[s] == 3) ? 7 : 2);
            len++;
          end
        end
        if (md[s] == 2) begin
          if (s < 2) nd[5] = 1'b1; else nd[s-2] = 1'b1;
        end
        if (md[s] == 3) begin
          if (s < 2) ne[5] = 1'b1; else ne[s-2] = 1'b1;
        end
      end
    end
    if (len > 255) len = 255;
    push_exp(h1, 1, 3); push_exp(h7, 1, 3);
    push_exp({8'(len), bx_num[3:0]}, 1, 8);
    push_exp(h6, 1, 3); push_exp(t5, 1, 3);
    for (int j = 0; j < 3; j++) push_exp({nd, ne}, 1, (ne != 0) ? 7 : 6);
  endtask

  task automatic rand_fields();
    evt_count   = 24'($urandom);
    bx_num      = 12'($urandom);
    cfeb_active = 5'($urandom);
    crate_id    = 8'($urandom);
    board_id    = 4'($urandom);
    ovlp_flags  = 5'($urandom);
    fifo_half   = 7'($urandom);
    fifo_empty  = 6'($urandom);
    fifo_full   = 6'($urandom);
  endtask

  task automatic apply_dav();
    anode_dav = (md[0] >= 1 && md[0] <= 3);
    tbrd_dav  = (md[1] >= 1 && md[1] <= 3) ? 2'(1 + $urandom % 3) : 2'b0;
    for (int k = 0; k < 5; k++) cfeb_dav[k] = (md[k+2] >= 1 && md[k+2] <= 3);
  endtask

  task automatic set_modes(input int m, input int n);
    for (int s = 0; s < 7; s++) begin md[s] = m; nw[s] = n; end
  endtask

  task automatic trig_once();
    build_exp();
    trig_accept = 1'b1;
    @(negedge clk);
    trig_accept = 1'b0;
  endtask

  task automatic start_event();
    @(negedge clk);
    clr = 1'b1;
    tag = ~tag;
    apply_dav();
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic drain_and_compare();
    int w;
    w = 0;
    while (rx_n < exp_n && w < 20000) begin @(negedge clk); w++; end
    repeat (30) @(negedge clk);
    check(rx_n == exp_n, 5, "record word count", 32'(rx_n), 32'(exp_n));
    for (int i = cmp_i; i < exp_n; i++)
      check(rx_w[i] == exp_w[i], exp_r[i], $sformatf("word %0d", i - cmp_i), 32'(rx_w[i]), 32'(exp_w[i]));
    for (int i = cmp_i; i < exp_n; i++)
      check(rx_w[i][17:13] == 5'b0 && rx_w[i][12] == exp_w[i][12], 4, "marker bits", 32'(rx_w[i][17:12]), 32'(exp_w[i][17:12]));
    cmp_i = exp_n;
    rx_n  = exp_n;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    set_modes(0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R11, R9)
    check(out_valid == 1'b0, 9, "out_valid after reset", 32'(out_valid), 0);
    check(src_ready == 7'b0, 11, "src_ready after reset", 32'(src_ready), 0);

    // R5: empty record
    rand_fields(); start_event(); trig_once(); drain_and_compare();

    // R5: accepts back to back while streaming, stalled output
    rdy_pct = 40;
    set_modes(0, 0); start_event();
    for (int k = 0; k < 4; k++) begin rand_fields(); trig_once(); end
    repeat (20) @(negedge clk);
    rand_fields(); trig_once();
    drain_and_compare();
    rdy_pct = 100;

    // R2: all sources, order
    set_modes(1, 2); rand_fields(); start_event(); trig_once(); drain_and_compare();

    // R6: silent flagged sources
    set_modes(2, 0); rand_fields(); start_event(); trig_once(); drain_and_compare();

    // R7: one cathode never ends, anode never ends
    set_modes(1, 1); md[5] = 3; nw[5] = 3; md[0] = 3; nw[0] = 2;
    rand_fields(); start_event(); trig_once(); drain_and_compare();

    // R2: unflagged sources with valid high are ignored
    set_modes(4, 3); md[3] = 1; nw[3] = 2;
    rand_fields(); start_event(); trig_once(); drain_and_compare();

    // R8: length saturation
    tmo_limit = 12'd1000;
    set_modes(0, 0); md[0] = 1; nw[0] = 300; md[6] = 1; nw[6] = 4;
    rand_fields(); start_event(); trig_once(); drain_and_compare();
    tmo_limit = 12'd20;

    // random events with back-pressure
    for (int e = 0; e < 40; e++) begin
      rdy_pct = 50 + int'($urandom % 51);
      tmo_limit = 12'(10 + $urandom % 20);
      for (int s = 0; s < 7; s++) begin
        case ($urandom % 6)
          0: begin md[s] = 0; nw[s] = 0; end
          1, 2: begin md[s] = 1; nw[s] = 1 + int'($urandom % 5); end
          3: begin md[s] = 2; nw[s] = 0; end
          4: begin md[s] = 3; nw[s] = 1 + int'($urandom % 3); end
          default: begin md[s] = 4; nw[s] = 2; end
        endcase
      end
      rand_fields(); start_event(); trig_once(); drain_and_compare();
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog expired: actual %0d words expected %0d", rx_n, exp_n);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule